// File: doc/BRIEF.md
# USB Endpoint Handshake Policy

This block keeps the handshake policy state for eight configurable USB endpoints (local index 0 to 7, endpoint numbers 4 to 11), plus stall flags for the three fixed endpoints 1 to 3. Each configurable endpoint holds four things: its setup (type, direction, max packet size), its DATA0/DATA1 toggle, the result code of its last transaction and a counter of NAKs in a row. The serial interface engine reports each finished transaction with an endpoint index and a result code. The block then updates the toggle and the counter.

When an IN endpoint's run of NAKs reaches a shared base count, the block raises a one-cycle request for the packet engine to send a zero-length or short packet, and the counter starts again. A global policy bit can stall any enabled endpoint on a FIFO overrun or underrun. A stall remains until the control processor clears it. All state is set and read through a small word-addressed register port that only the control processor uses.

Top module: `usb_ep_policy`

## Requirements
- R1: After reset, every register reads zero: all endpoints are disabled, toggles are 0, counters are 0 and no stall is set. All outputs are low.
- R2: Register map, 16-bit words:
  - Addresses 0 to 7 are the endpoint setup words, with type in [1:0] (00 disabled, 01 iso, 10 bulk, 11 interrupt), direction in [2] (1 = IN), toggle in [3], last result in [5:4] and max packet size in [15:6].
  - Addresses 8 to 15 are the endpoint NAK words, with stall in [0] and the NAK counter in [4:1].
  - Address 16 is the policy word, with the FIFO-error stall enable in [0], the base NAK count in [4:1] and the fixed-endpoint stalls in [7:5].
  - Every other address reads zero.
- R3: An endpoint of type 00 ignores transaction events and FIFO errors: its toggle, counter, last result and stall stay unchanged.
- R4: An ACK result (01) on an enabled, unstalled endpoint inverts its toggle, clears its counter and records 01 as the last result.
- R5: A NAK result (10) on an enabled, unstalled endpoint records 10 and increments the counter, which wraps modulo 16. The results ERR (11) and clear (00) are recorded, clear the counter and leave the toggle alone.
- R6: When a NAK on an enabled, unstalled IN endpoint brings its counter equal to a nonzero base count, force_short for that endpoint is high for exactly the next cycle, and the counter reads 0. OUT endpoints never force a short packet, and neither does a base count of 0.
- R7: While the enable bit is set, a FIFO overrun or underrun on an enabled endpoint sets its stall, which shows at ep_stall on the next cycle. While the enable bit is clear, FIFO flags have no effect.
- R8: A stalled endpoint ignores transaction events. Its stall stays set until the processor writes 0 to it. A FIFO-error stall in the same cycle as a processor clear wins.
- R9: Policy bits [7:5] drive fixed_stall[2:0], with bit 5 for endpoint 1, and only processor writes change them.
- R10: A processor write to an endpoint word overrides any transaction update to the same fields in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| txn_valid | input | 1 | Transaction-complete event |
| txn_ep | input | 3 | Local endpoint index of the event |
| txn_res | input | 2 | Result: 00 clear, 01 ACK, 10 NAK, 11 ERR |
| fifo_ovr | input | 8 | Per-endpoint FIFO overrun flags |
| fifo_unr | input | 8 | Per-endpoint FIFO underrun flags |
| ep_stall | output | 8 | Per-endpoint stall state |
| ep_toggle | output | 8 | Per-endpoint data toggle |
| force_short | output | 8 | One-cycle short-packet request |
| fixed_stall | output | 3 | Stall flags for endpoints 1 to 3 |

## Verification
A wrong toggle or stall bit shows on ep_toggle or ep_stall on the cycle right after the event that caused it. A counter that has drifted stays hidden until the NAK that should reach the base count, when force_short comes early, late or not at all. Read-back of the NAK word exposes the counter directly. The bench compares every output on every cycle with a model, and it reads back registers often during random traffic so that hidden counter errors surface within a few cycles.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    RES_CLEAR = 2'b00,
    RES_ACK   = 2'b01,
    RES_NAK   = 2'b10,
    RES_ERR   = 2'b11
  } txn_res_e;

  typedef enum logic [1:0] {
    EPT_OFF  = 2'b00,
    EPT_ISO  = 2'b01,
    EPT_BULK = 2'b10,
    EPT_INTR = 2'b11
  } ep_type_e;
endpackage

// File: rtl/usb_ep_rst_sync.sv
module usb_ep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
  import usb_ep_pkg::*;
#(
  parameter int MPS_W = 10,
  parameter int NAK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_we,
  input  logic             nak_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             txn_hit,
  input  logic [1:0]       txn_res,
  input  logic             fifo_err,
  input  logic             fe_en,
  input  logic [NAK_W-1:0] base,
  output logic [REG_W-1:0] desc_rd,
  output logic [REG_W-1:0] nak_rd,
  output logic             stall,
  output logic             toggle,
  output logic             force_short
);
  localparam int MPS_LSB = 6;

  logic [1:0]       typ_q, typ_n;
  logic             dir_q, dir_n;
  logic             tog_q, tog_n;
  logic [1:0]       last_q, last_n;
  logic [MPS_W-1:0] mps_q, mps_n;
  logic [NAK_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             stl_q, stl_n;
  logic             fs_q, fs_n;
  logic             enabled, st_en;
  txn_res_e         res;

  assign res     = txn_res_e'(txn_res);
  assign enabled = (typ_q != EPT_OFF);
  assign cnt_inc = cnt_q + 1'b1;
  assign st_en   = txn_hit | desc_we | nak_we | fifo_err;

  // next-state
  always_comb begin
    typ_n  = typ_q;
    dir_n  = dir_q;
    tog_n  = tog_q;
    last_n = last_q;
    mps_n  = mps_q;
    cnt_n  = cnt_q;
    stl_n  = stl_q;
    fs_n   = 1'b0;
    if (txn_hit && enabled && !stl_q) begin
      last_n = res;
      case (res)
        RES_NAK: begin
          if (dir_q && (base != '0) && (cnt_inc == base)) begin
            cnt_n = '0;
            fs_n  = 1'b1;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        RES_ACK: begin
          cnt_n = '0;
          tog_n = ~tog_q;
        end
        default: cnt_n = '0;
      endcase
    end
    if (desc_we) begin
      typ_n  = wdata[1:0];
      dir_n  = wdata[2];
      tog_n  = wdata[3];
      last_n = wdata[5:4];
      mps_n  = wdata[MPS_LSB +: MPS_W];
    end
    if (nak_we) begin
      stl_n = wdata[0];
      cnt_n = wdata[1 +: NAK_W];
    end
    if (fe_en && fifo_err && enabled) stl_n = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q  <= '0;
      dir_q  <= 1'b0;
      tog_q  <= 1'b0;
      last_q <= '0;
      mps_q  <= '0;
      cnt_q  <= '0;
      stl_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= fs_n;
      if (st_en) begin
        typ_q  <= typ_n;
        dir_q  <= dir_n;
        tog_q  <= tog_n;
        last_q <= last_n;
        mps_q  <= mps_n;
        cnt_q  <= cnt_n;
        stl_q  <= stl_n;
      end
    end
  end

  assign desc_rd     = REG_W'({mps_q, last_q, tog_q, dir_q, typ_q});
  assign nak_rd      = REG_W'({cnt_q, stl_q});
  assign stall       = stl_q;
  assign toggle      = tog_q;
  assign force_short = fs_q;
endmodule

// File: rtl/usb_ep_policy.sv
module usb_ep_policy
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int MPS_W     = 10,
  parameter int NAK_W     = 4,
  parameter int NUM_FIXED = 3,
  parameter int ADDR_W    = $clog2(2*NUM_EP+1),
  parameter int EP_W      = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              txn_valid,
  input  logic [EP_W-1:0]   txn_ep,
  input  logic [1:0]        txn_res,
  input  logic [NUM_EP-1:0] fifo_ovr,
  input  logic [NUM_EP-1:0] fifo_unr,
  output logic [NUM_EP-1:0] ep_stall,
  output logic [NUM_EP-1:0] ep_toggle,
  output logic [NUM_EP-1:0] force_short,
  output logic [NUM_FIXED-1:0] fixed_stall
);
  localparam int POL_ADDR = 2*NUM_EP;
  localparam int POL_W    = 1 + NAK_W + NUM_FIXED;

  logic                 rst_n_i;
  logic                 pol_we;
  logic                 fe_q, fe_n;
  logic [NAK_W-1:0]     base_q, base_n;
  logic [NUM_FIXED-1:0] fix_q, fix_n;
  logic [REG_W-1:0]     desc_rd [NUM_EP];
  logic [REG_W-1:0]     nak_rd  [NUM_EP];

  usb_ep_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign pol_we = cfg_wr && (cfg_addr == ADDR_W'(POL_ADDR));

  always_comb begin
    fe_n   = fe_q;
    base_n = base_q;
    fix_n  = fix_q;
    if (pol_we) begin
      fe_n   = cfg_wdata[0];
      base_n = cfg_wdata[1 +: NAK_W];
      fix_n  = cfg_wdata[1+NAK_W +: NUM_FIXED];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fe_q   <= 1'b0;
      base_q <= '0;
      fix_q  <= '0;
    end else if (pol_we) begin
      fe_q   <= fe_n;
      base_q <= base_n;
      fix_q  <= fix_n;
    end
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usb_ep_slot #(.MPS_W(MPS_W), .NAK_W(NAK_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n_i),
      .desc_we     (cfg_wr && (cfg_addr == ADDR_W'(i))),
      .nak_we      (cfg_wr && (cfg_addr == ADDR_W'(NUM_EP+i))),
      .wdata       (cfg_wdata),
      .txn_hit     (txn_valid && (txn_ep == EP_W'(i))),
      .txn_res     (txn_res),
      .fifo_err    (fifo_ovr[i] | fifo_unr[i]),
      .fe_en       (fe_q),
      .base        (base_q),
      .desc_rd     (desc_rd[i]),
      .nak_rd      (nak_rd[i]),
      .stall       (ep_stall[i]),
      .toggle      (ep_toggle[i]),
      .force_short (force_short[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_EP; k++) begin
      if (cfg_addr == ADDR_W'(k))        cfg_rdata = desc_rd[k];
      if (cfg_addr == ADDR_W'(NUM_EP+k)) cfg_rdata = nak_rd[k];
    end
    if (cfg_addr == ADDR_W'(POL_ADDR)) cfg_rdata = REG_W'(POL_W'({fix_q, base_q, fe_q}));
  end

  assign fixed_stall = fix_q;
endmodule

// File: rtl/usb_ep_policy_chk.sv
module usb_ep_policy_chk
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP    = 8,
  parameter int NUM_FIXED = 3,
  parameter int ADDR_W    = 5,
  parameter int EP_W      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic                 txn_valid,
  input logic [EP_W-1:0]      txn_ep,
  input logic [1:0]           txn_res,
  input logic [NUM_EP-1:0]    fifo_ovr,
  input logic [NUM_EP-1:0]    fifo_unr,
  input logic [NUM_EP-1:0]    ep_stall,
  input logic [NUM_EP-1:0]    ep_toggle,
  input logic [NUM_EP-1:0]    force_short,
  input logic [NUM_FIXED-1:0] fixed_stall
);
  // R6: only one endpoint event per cycle, so at most one request
  assert_fs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_short));

  // R9: fixed stalls move only on a policy write
  assert_fixed_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fixed_stall) |-> $past(cfg_wr && cfg_addr == ADDR_W'(2*NUM_EP)));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    // R6: a request follows a NAK event on that endpoint
    assert_fs_after_nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
      force_short[i] |-> $past(txn_valid && txn_ep == EP_W'(i) && txn_res == RES_NAK));

    // R7: stall rises from a FIFO flag or a processor write
    assert_stall_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_stall[i]) |-> $past(fifo_ovr[i] || fifo_unr[i] ||
                                   (cfg_wr && cfg_addr == ADDR_W'(NUM_EP+i))));

    // R8: stall falls only on a processor write
    assert_stall_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ep_stall[i]) |-> $past(cfg_wr && cfg_addr == ADDR_W'(NUM_EP+i)));

    // R4: toggle moves only on ACK or a setup write
    assert_toggle_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ep_toggle[i]) |-> $past((txn_valid && txn_ep == EP_W'(i) && txn_res == RES_ACK) ||
                                       (cfg_wr && cfg_addr == ADDR_W'(i))));

    // R8: a stalled endpoint keeps its toggle unless written
    assert_stalled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ep_stall[i]) && !$past(cfg_wr && cfg_addr == ADDR_W'(i))) |-> $stable(ep_toggle[i]));
  end
endmodule

bind usb_ep_policy usb_ep_policy_chk #(
  .NUM_EP(NUM_EP), .NUM_FIXED(NUM_FIXED), .ADDR_W(ADDR_W), .EP_W(EP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .txn_valid(txn_valid), .txn_ep(txn_ep), .txn_res(txn_res),
  .fifo_ovr(fifo_ovr), .fifo_unr(fifo_unr), .ep_stall(ep_stall),
  .ep_toggle(ep_toggle), .force_short(force_short), .fixed_stall(fixed_stall)
);

// File: tb/usb_ep_policy_test.sv
module usb_ep_policy_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk, rst_n, cfg_wr, txn_valid;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [2:0]  txn_ep;
  logic [1:0]  txn_res;
  logic [7:0]  fifo_ovr, fifo_unr, ep_stall, ep_toggle, force_short;
  logic [2:0]  fixed_stall;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [1:0] m_typ [NE];
  logic       m_dir [NE];
  logic       m_tog [NE];
  logic [1:0] m_last[NE];
  logic [9:0] m_mps [NE];
  logic [3:0] m_cnt [NE];
  logic       m_stl [NE];
  logic       m_fs  [NE];
  logic       m_fe;
  logic [3:0] m_base;
  logic [2:0] m_fix;

  usb_ep_policy uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
    .txn_ep(txn_ep), .txn_res(txn_res), .fifo_ovr(fifo_ovr), .fifo_unr(fifo_unr),
    .ep_stall(ep_stall), .ep_toggle(ep_toggle), .force_short(force_short),
    .fixed_stall(fixed_stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_val(logic [4:0] a);
    if (a < 8)   return {m_mps[a], m_last[a], m_tog[a], m_dir[a], m_typ[a]};
    if (a < 16)  return {11'd0, m_cnt[a-8], m_stl[a-8]};
    if (a == 16) return {8'd0, m_fix, m_base, m_fe};
    return 16'd0;
  endfunction

  task automatic check_outputs();
    logic [7:0] es, et, ef;
    for (int i = 0; i < NE; i++) begin
      es[i] = m_stl[i]; et[i] = m_tog[i]; ef[i] = m_fs[i];
    end
    chk("R4", "ep_toggle", ep_toggle, et);
    chk("R6", "force_short", force_short, ef);
    chk("R7", "ep_stall", ep_stall, es);
    chk("R9", "fixed_stall", fixed_stall, m_fix);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    cfg_wr = 0; txn_valid = 0; fifo_ovr = 0; fifo_unr = 0; cfg_addr = a;
    #1;
    chk(tag, $sformatf("rdata@%0d", a), cfg_rdata, reg_val(a));
  endtask

  task automatic model_step(bit wr, logic [4:0] a, logic [15:0] d, bit tv,
                            logic [2:0] te, logic [1:0] tr, logic [7:0] ov, logic [7:0] un);
    bit fe_o;
    logic [3:0] base_o;
    fe_o = m_fe; base_o = m_base;
    for (int i = 0; i < NE; i++) begin
      bit en, hit;
      logic [3:0] inc;
      en  = (m_typ[i] != 2'b00);
      hit = tv && (te == i) && en && !m_stl[i];
      inc = m_cnt[i] + 4'd1;
      m_fs[i] = 0;
      if (hit) begin
        m_last[i] = tr;
        if (tr == 2'b10) begin
          if (m_dir[i] && base_o != 0 && inc == base_o) begin
            m_cnt[i] = 0; m_fs[i] = 1;
          end else m_cnt[i] = inc;
        end else begin
          m_cnt[i] = 0;
          if (tr == 2'b01) m_tog[i] = ~m_tog[i];
        end
      end
      if (wr && a == i) begin
        m_typ[i] = d[1:0]; m_dir[i] = d[2]; m_tog[i] = d[3];
        m_last[i] = d[5:4]; m_mps[i] = d[15:6];
      end
      if (wr && a == 8 + i) begin
        m_stl[i] = d[0]; m_cnt[i] = d[4:1];
      end
      if (fe_o && (ov[i] | un[i]) && en) m_stl[i] = 1;
    end
    if (wr && a == 16) begin
      m_fe = d[0]; m_base = d[4:1]; m_fix = d[7:5];
    end
  endtask

  task automatic cyc(bit wr, logic [4:0] a, logic [15:0] d, bit tv,
                     logic [2:0] te, logic [1:0] tr, logic [7:0] ov, logic [7:0] un);
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
    txn_valid = tv; txn_ep = te; txn_res = tr; fifo_ovr = ov; fifo_unr = un;
    model_step(wr, a, d, tv, te, tr, ov, un);
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic txn(logic [2:0] e, logic [1:0] r);
    cyc(0, 0, 0, 1, e, r, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; txn_valid = 0;
    txn_ep = 0; txn_res = 0; fifo_ovr = 0; fifo_unr = 0;
    for (int i = 0; i < NE; i++) begin
      m_typ[i] = 0; m_dir[i] = 0; m_tog[i] = 0; m_last[i] = 0;
      m_mps[i] = 0; m_cnt[i] = 0; m_stl[i] = 0; m_fs[i] = 0;
    end
    m_fe = 0; m_base = 0; m_fix = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "outputs", {ep_stall, ep_toggle, force_short, 5'd0, fixed_stall}, 32'd0);
    for (int a = 0; a < 18; a++) rd(a[4:0], "R1");

    // R2: setup words and policy
    wr(0, {10'd64, 2'b00, 1'b0, 1'b1, 2'b10});    // IN bulk
    wr(1, {10'd512, 2'b00, 1'b0, 1'b0, 2'b10});   // OUT bulk
    wr(3, {10'd8, 2'b00, 1'b0, 1'b1, 2'b11});     // IN interrupt
    wr(16, {8'd0, 3'b000, 4'd3, 1'b1});
    rd(0, "R2"); rd(1, "R2"); rd(16, "R2"); rd(20, "R2");

    // R4: ACK flips toggle
    txn(0, 2'b01); rd(0, "R4");
    // R5 / R6: NAK run on IN endpoint reaches base 3
    txn(0, 2'b10); rd(8, "R5");
    txn(0, 2'b10);
    txn(0, 2'b10);
    chk("R6", "force_short at base", force_short, 8'h01);
    rd(8, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "force_short one cycle", force_short, 8'h00);
    txn(0, 2'b10); txn(0, 2'b11); rd(0, "R5"); rd(8, "R5");
    txn(0, 2'b00); rd(0, "R5");
    // R6: OUT endpoint never forces
    for (int k = 0; k < 5; k++) txn(1, 2'b10);
    rd(9, "R6");
    // R3: disabled endpoint ignores events and FIFO errors
    txn(2, 2'b01);
    cyc(0, 0, 0, 0, 0, 0, 8'h04, 0);
    rd(2, "R3"); rd(10, "R3");
    chk("R3", "disabled stall", ep_stall[2], 1'b0);
    // R7: FIFO underrun stalls endpoint 0
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h01);
    chk("R7", "stall set", ep_stall[0], 1'b1);
    // R8: stalled endpoint ignores ACK and NAK
    txn(0, 2'b01); txn(0, 2'b10); rd(0, "R8"); rd(8, "R8");
    wr(8, 16'd0);
    chk("R8", "stall cleared", ep_stall[0], 1'b0);
    // R8: FIFO stall wins over a same-cycle clear
    cyc(1, 8, 16'd0, 0, 0, 0, 8'h01, 0);
    chk("R8", "fifo beats clear", ep_stall[0], 1'b1);
    wr(8, 16'd0);
    // R7: policy off, FIFO flags ignored
    wr(16, {8'd0, 3'b000, 4'd3, 1'b0});
    cyc(0, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
    for (int a = 8; a < 16; a++) rd(a[4:0], "R7");
    // R9: fixed endpoint stalls
    wr(16, {8'd0, 3'b101, 4'd3, 1'b0});
    chk("R9", "fixed_stall", fixed_stall, 3'b101);
    // R10: write beats same-cycle ACK
    cyc(1, 0, {10'd32, 2'b00, 1'b0, 1'b1, 2'b10}, 1, 0, 2'b01, 0, 0);
    rd(0, "R10");
    // R6: base zero never forces; counter wraps
    wr(16, {8'd0, 3'b000, 4'd0, 1'b1});
    for (int k = 0; k < 20; k++) txn(3, 2'b10);
    rd(11, "R6");

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit w, tv;
      logic [4:0] a;
      logic [15:0] d;
      logic [7:0] ov, un;
      w  = ($urandom % 8) == 0;
      a  = 5'($urandom % 18);
      d  = 16'($urandom);
      if (a == 16) d[4:1] = 4'($urandom % 6);
      tv = ($urandom % 4) != 0;
      ov = (($urandom % 32) == 0) ? 8'(1 << ($urandom % 8)) : 8'd0;
      un = (($urandom % 32) == 0) ? 8'(1 << ($urandom % 8)) : 8'd0;
      cyc(w, a, d, tv, 3'($urandom % 8), (($urandom % 3) == 0) ? 2'($urandom) : 2'b10, ov, un);
      if ((n % 16) == 0) rd(5'($urandom % 18), "R2");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule